// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a read-only slave on a 32-bit bus that uses a request/acknowledge handshake. It lets a processor fetch characters from a keyboard encoder. The encoder presents an 8-bit character together with a strobe. The port keeps the most recent character in a one-entry holding register and raises a ready flag, so that software can poll for new keys.

The processor starts a read by driving an address, setting the read/write line to read, and raising its request line. The port answers with an acknowledge and a data-valid output for as long as that request is held with a matching address. Two words are visible:

- the character word, which holds the character in its low byte;
- the status word, which holds the ready flag.

The ready flag is never changed while a bus request is active. A strobe edge that arrives during a request is held as pending and applied once the request is removed. Reading the character word consumes the key: it clears both the flag and any pending request.

Top module: `keyin_port`

## Requirements
- R1: After reset the ready flag is 0, and both the acknowledge and the data-valid output are low.
- R2: The port responds only when address bits 31..3 equal the same bits of BASE_ADDR (default 0x0000_4000). Bits 1..0 are ignored.
- R3: The acknowledge and data-valid outputs are high only while all three of these are true: the request line is high, the address matches, and the read/write line is 1 (read). A write request gets no response.
- R4: The acknowledge and data-valid outputs fall in the same cycle in which the request line falls.
- R5: With address bit 2 = 0, the read word carries the held character in bits 7..0, and bits 31..8 are zero.
- R6: With address bit 2 = 1, the read word carries the ready flag in bit 0, and every other bit is zero.
- R7: A rising edge on the key strobe loads the character. If the request line stays low, the ready flag reads 1 from the third rising clock edge after the strobe is first high.
- R8: A strobe edge that arrives while the request line is high does not change the ready flag during that request. The flag becomes 1 after the first clock edge at which the request line is low.
- R9: A character-word read clears the ready flag and any pending set. A strobe edge that arrives during such a read is discarded.
- R10: Holding the strobe high does not set the flag again; only a low-to-high transition sets it.
- R11: While the data-valid output is low, the read data bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, used for all logic |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 32 | Bus address |
| bus_rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_mrdy | input | 1 | Request line from the bus master |
| bus_srdy | output | 1 | Acknowledge from this port |
| bus_rdata | output | 32 | Read data word |
| bus_rdata_en | output | 1 | Read data valid (stands in for a tri-state enable) |
| key_char | input | 8 | Character from the keyboard encoder |
| key_strobe | input | 1 | Character strobe from the encoder |

## Verification
The assertions check on every cycle that:
- the acknowledge appears only for a read request and drops when the request drops;
- the read bus is zero when no data is driven;
- the status word has clean upper bits;
- the flag never rises in a cycle that follows an active request;
- a character read always leaves the flag cleared.

Some behaviours span several transactions, and only the bench scenarios can show them:
- the deferred set that lands once a request ends;
- a strobe edge lost to a character read;
- a strobe held high producing a single set;
- the exact latency from strobe to flag.

// File: rtl/keyin_pkg.sv
package keyin_pkg;

   typedef enum logic {
      SEL_CHAR   = 1'b0,
      SEL_STATUS = 1'b1
   } keyin_sel_e;

   typedef struct packed {
      logic       respond;   // request, read and address match all true
      logic       take_char; // character word being read
      keyin_sel_e sel;
   } keyin_req_t;

endpackage

// File: rtl/keyin_strobe_sync.sv
module keyin_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_o
);
   logic strobe_s;
   logic strobe_prev;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("keyin_strobe_sync: STAGES must be non-negative");
      end
      if (STAGES == 0) begin : g_direct
         assign strobe_s = strobe_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], strobe_in};
         end
         assign strobe_s = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev <= 1'b0;
      else        strobe_prev <= strobe_s;
   end

   assign rise_o = strobe_s & ~strobe_prev;
endmodule

// File: rtl/keyin_decode.sv
module keyin_decode
   import keyin_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          SEL_BIT   = 2,
   parameter logic [31:0] BASE_ADDR = 32'h0000_4000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_nwr,
   input  logic              mrdy,
   output keyin_req_t        req_o
);
   localparam int MATCH_LO = SEL_BIT + 1;
   localparam logic [ADDR_W-1:0] MATCH_MASK = ~((ADDR_W'(1) << MATCH_LO) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] BASE_W     = ADDR_W'(BASE_ADDR);

   generate
      if (SEL_BIT + 1 >= ADDR_W) begin : g_bad_sel
         $error("keyin_decode: SEL_BIT leaves no address bits to match");
      end
   endgenerate

   logic hit;
   assign hit = (((addr ^ BASE_W) & MATCH_MASK) == '0);

   always_comb begin
      req_o.sel       = addr[SEL_BIT] ? SEL_STATUS : SEL_CHAR;
      req_o.respond   = mrdy & rd_nwr & hit;
      req_o.take_char = req_o.respond & (req_o.sel == SEL_CHAR);
   end
endmodule

// File: rtl/keyin_flag.sv
module keyin_flag #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic [CHAR_W-1:0] char_in,
   input  logic              mrdy,
   input  logic              clr,
   output logic [CHAR_W-1:0] char_q,
   output logic              kin_q
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q <= '0;
         kin_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (rise) char_q <= char_in;
         if (clr) begin
            kin_q  <= 1'b0;
            pend_q <= 1'b0;
         end else if (!mrdy) begin
            if (pend_q | rise) kin_q <= 1'b1;
            pend_q <= 1'b0;
         end else if (rise) begin
            pend_q <= 1'b1;
         end
      end
   end

   // R8: flag only rises after a cycle with the request line low
   a_r8_no_rise_in_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kin_q) |-> !$past(mrdy));
   // R9: a character read leaves the flag cleared
   a_r9_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !kin_q);
   // R7: an edge with the bus idle sets the flag on the next edge
   a_r7_set_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !mrdy && !clr) |=> kin_q);
endmodule

// File: rtl/keyin_rdmux.sv
module keyin_rdmux
   import keyin_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CHAR_W   = 8,
   parameter int FLAG_BIT = 0
) (
   input  keyin_req_t        req,
   input  logic [CHAR_W-1:0] char_q,
   input  logic              kin_q,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en
);
   generate
      if (CHAR_W > DATA_W) begin : g_bad_char
         $error("keyin_rdmux: CHAR_W exceeds DATA_W");
      end
      if (FLAG_BIT >= DATA_W) begin : g_bad_flag
         $error("keyin_rdmux: FLAG_BIT outside data word");
      end
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic char_bit;
         logic stat_bit;
         if (i < CHAR_W) begin : g_cb
            assign char_bit = char_q[i];
         end else begin : g_cz
            assign char_bit = 1'b0;
         end
         if (i == FLAG_BIT) begin : g_sf
            assign stat_bit = kin_q;
         end else begin : g_sz
            assign stat_bit = 1'b0;
         end
         assign rdata[i] = req.respond &
                           ((req.sel == SEL_STATUS) ? stat_bit : char_bit);
      end
   endgenerate

   assign rdata_en = req.respond;
endmodule

// File: rtl/keyin_port.sv
module keyin_port
   import keyin_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 32,
   parameter int          CHAR_W      = 8,
   parameter int          SEL_BIT     = 2,
   parameter int          FLAG_BIT    = 0,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] BASE_ADDR   = 32'h0000_4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd_nwr,
   input  logic              bus_mrdy,
   output logic              bus_srdy,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_en,
   input  logic [CHAR_W-1:0] key_char,
   input  logic              key_strobe
);
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

   keyin_req_t        req;
   logic              rise;
   logic [CHAR_W-1:0] char_q;
   logic              kin_q;

   keyin_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .strobe_in(key_strobe), .rise_o(rise));

   keyin_decode #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr(bus_addr), .rd_nwr(bus_rd_nwr), .mrdy(bus_mrdy), .req_o(req));

   keyin_flag #(.CHAR_W(CHAR_W)) u_flag (
      .clk(clk), .rst_n(rst_n), .rise(rise), .char_in(key_char),
      .mrdy(bus_mrdy), .clr(req.take_char), .char_q(char_q), .kin_q(kin_q));

   keyin_rdmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .FLAG_BIT(FLAG_BIT)) u_mux (
      .req(req), .char_q(char_q), .kin_q(kin_q),
      .rdata(bus_rdata), .rdata_en(bus_rdata_en));

   assign bus_srdy = req.respond;

   // R3: acknowledge only for an active read request
   a_r3_ack_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_srdy |-> (bus_mrdy && bus_rd_nwr));
   // R4: acknowledge gone once the request drops
   a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_mrdy) |-> (!bus_srdy && !bus_rdata_en));
   // R11: quiet bus carries zeros
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata_en |-> (bus_rdata == '0));
   // R6: status word has only the flag bit
   a_r6_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_srdy && bus_addr[SEL_BIT]) |-> ((bus_rdata & ~FLAG_MASK) == '0));
endmodule

// File: tb/test_keyin_port.sv
module test_keyin_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = 32'h0;
   logic        bus_rd_nwr = 1'b0;
   logic        bus_mrdy = 1'b0;
   logic        bus_srdy;
   logic [31:0] bus_rdata;
   logic        bus_rdata_en;
   logic [7:0]  key_char = 8'h0;
   logic        key_strobe = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] CHAR_A = 32'h0000_4000;
   localparam logic [31:0] STAT_A = 32'h0000_4004;

   always #2 clk = ~clk;

   keyin_port i_keyin_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_nwr(bus_rd_nwr),
      .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy), .bus_rdata(bus_rdata),
      .bus_rdata_en(bus_rdata_en), .key_char(key_char), .key_strobe(key_strobe));

   // {expect response, rd_nwr, address}
   localparam logic [33:0] VEC [0:8] = '{
      {1'b1, 1'b1, 32'h0000_4000},
      {1'b1, 1'b1, 32'h0000_4001},
      {1'b1, 1'b1, 32'h0000_4003},
      {1'b1, 1'b1, 32'h0000_4004},
      {1'b1, 1'b1, 32'h0000_4007},
      {1'b0, 1'b1, 32'h0000_4008},
      {1'b0, 1'b1, 32'h0000_3FFC},
      {1'b0, 1'b1, 32'h8000_4000},
      {1'b0, 1'b0, 32'h0000_4000}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [31:0] a, input int hold, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_nwr = 1'b1; bus_mrdy = 1'b1;
      repeat (hold) @(negedge clk);
      #1 d = bus_rdata;
      bus_mrdy = 1'b0;
      #0.5;
      check(!bus_srdy && !bus_rdata_en, "R4", {30'b0, bus_srdy, bus_rdata_en}, 32'h0);
      @(negedge clk);
   endtask

   task automatic press(input logic [7:0] c);
      @(negedge clk);
      key_char = c; key_strobe = 1'b1;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!bus_srdy && !bus_rdata_en && bus_rdata == 0, "R1", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(STAT_A, 1, d);
      check(d == 32'h0, "R1", d, 32'h0);

      // R2 R3 R11: decode table
      foreach (VEC[i]) begin
         @(negedge clk);
         bus_addr = VEC[i][31:0]; bus_rd_nwr = VEC[i][32]; bus_mrdy = 1'b1;
         #1;
         check(bus_srdy == VEC[i][33], "R2/R3 srdy", {31'b0, bus_srdy}, {31'b0, VEC[i][33]});
         check(bus_rdata_en == VEC[i][33], "R3 rdata_en", {31'b0, bus_rdata_en}, {31'b0, VEC[i][33]});
         if (!VEC[i][33]) check(bus_rdata == 0, "R11", bus_rdata, 32'h0);
         @(negedge clk);
         bus_mrdy = 1'b0;
      end
      @(negedge clk);

      // R7: set while idle, R5 character word, R9 clear
      press(8'h41);
      repeat (3) @(negedge clk);
      key_strobe = 1'b0;
      do_read(STAT_A, 1, d);
      check(d == 32'h1, "R7", d, 32'h1);
      do_read(CHAR_A, 2, d);
      check(d == 32'h41, "R5", d, 32'h41);
      do_read(STAT_A, 1, d);
      check(d == 32'h0, "R9", d, 32'h0);

      // R8: edge during a status read is deferred
      @(negedge clk);
      bus_addr = STAT_A; bus_rd_nwr = 1'b1; bus_mrdy = 1'b1;
      key_char = 8'h5A; key_strobe = 1'b1;
      repeat (8) @(negedge clk);
      #1;
      check(bus_rdata == 32'h0, "R8 held", bus_rdata, 32'h0);
      bus_mrdy = 1'b0;
      @(negedge clk);
      key_strobe = 1'b0;
      do_read(STAT_A, 1, d);
      check(d == 32'h1, "R8 applied", d, 32'h1);
      do_read(CHAR_A, 1, d);
      check(d == 32'h5A, "R5 upper zero", d, 32'h5A);

      // R10: strobe held high sets only once
      press(8'h33);
      repeat (4) @(negedge clk);
      do_read(STAT_A, 1, d);
      check(d == 32'h1, "R10 first", d, 32'h1);
      do_read(CHAR_A, 1, d);
      check(d == 32'h33, "R10 char", d, 32'h33);
      repeat (6) @(negedge clk);
      do_read(STAT_A, 1, d);
      check(d == 32'h0, "R10 no reset", d, 32'h0);
      key_strobe = 1'b0;
      repeat (4) @(negedge clk);

      // R9: edge during a character read is discarded
      @(negedge clk);
      bus_addr = CHAR_A; bus_rd_nwr = 1'b1; bus_mrdy = 1'b1;
      key_char = 8'h77; key_strobe = 1'b1;
      repeat (8) @(negedge clk);
      bus_mrdy = 1'b0;
      repeat (2) @(negedge clk);
      key_strobe = 1'b0;
      do_read(STAT_A, 1, d);
      check(d == 32'h0, "R9 pending dropped", d, 32'h0);

      // R6: status word upper bits after a set
      press(8'hFF);
      repeat (4) @(negedge clk);
      key_strobe = 1'b0;
      do_read(32'h0000_4006, 1, d);
      check(d == 32'h1, "R6", d, 32'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule